// File: doc/BRIEF.md
# Frame Tracking Error Detector

This block watches two vertical-sync pulse streams, one from the video input and one from the scaled output. Both are timed against the same reference clock. It reports how far the output frame timing has drifted from the input timing. An external control loop uses the signed error word to trim the output pixel clock, so that frames are neither dropped nor repeated.

The detector runs in one of two modes, picked at run time:

- **Phase mode** drives the loop toward a whole number of frames of latency.
- **Frequency mode** matches only the frame rate, so the latency may settle at a fractional number of frames.

A fixed ratio code lets the input and output frame rates differ. The detector then measures windows of several input frames against windows of several output frames.

The block also holds the open-loop period for the clock synthesizer. Software writes this period one byte at a time into a shadow register. It copies into the active period only on a rising edge of an update strobe.

Top module: `frame_track_errdet`

## Requirements
- R1: Writes with `cfg_we` high store `cfg_wdata` into shadow byte `cfg_addr` (byte 0 is bits 7:0, byte 3 is bits 31:24). On the clock edge that sees `period_upd` high after it was low on the previous edge, the whole shadow is copied to `period_active`. The new value is visible from the next cycle.
- R2: `period_active` does not change while `period_upd` stays low, stays high, or falls, even when shadow bytes are written meanwhile.
- R3: With `err_mode` = 0 the error word is the phase error. With `err_mode` = 1 it is the frequency error.
- R4: `ratio_sel` codes give input-frames:output-frames per window as follows: 0 = 1:1, 1 = 2:1, 2 = 1:2, 3 = 5:2, 4 = 2:5.
- R5: With `ratio_sel` at 5, 6 or 7, `err_word` stays 0 and `err_valid` never asserts.
- R6: A window boundary falls on every Nth rising edge of `vs_in`, counting from the first edge after idle. The same holds for `vs_out` with M.
- R7: Frequency error equals the latest output window length minus the input window length just completed, in reference clocks. It is a signed 24-bit value.
- R8: Phase error is the time of the nearest output boundary minus the time of the input boundary, in reference clocks. The nearest boundary is either the latest one or the next one projected one output window later. On a tie the earlier boundary wins.
- R9: `err_valid` is high for exactly one cycle, the cycle after an input boundary. This happens only when an input window and an output window have both been measured. `err_word` updates in that same cycle.
- R10: A change of `ratio_sel` or `err_mode` returns the detector to idle: the next cycle shows `err_word` = 0 and `err_valid` = 0. No result appears until new windows have been measured.
- R11: After reset, `err_word` is 0, `err_valid` is 0 and `period_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vs_in | input | 1 | Input vertical-sync pulse |
| vs_out | input | 1 | Output vertical-sync pulse |
| ratio_sel | input | 3 | Frame-rate ratio code |
| err_mode | input | 1 | 0 phase error, 1 frequency error |
| cfg_we | input | 1 | Shadow byte write enable |
| cfg_addr | input | 2 | Shadow byte index |
| cfg_wdata | input | 8 | Shadow byte data |
| period_upd | input | 1 | Update strobe, acts on rising edge |
| period_active | output | 32 | Active open-loop period |
| err_word | output | 24 | Signed error word |
| err_valid | output | 1 | One-cycle result strobe |

## Verification
The bench runs every ratio code under locked and detuned pulse trains and compares the last error of each run with values worked out by hand from the pulse periods. A window count that is off by one frame would give an error off by a whole frame period. The phase cases place the output boundary just before and just after the input boundary. A design that always took the latest output boundary, instead of the nearest one, would report a large negative error where a small positive one is due.

The strobe tests write bytes with the strobe low, hold it high and let it fall. A level-sensitive load would be caught at once. Changing the mode in the middle of a run, and selecting an invalid ratio code, expose a detector that keeps stale windows or reports results it should not.

// File: rtl/ftd_pkg.sv
package ftd_pkg;

   // decoded ratio: frames per window on each side
   typedef struct packed {
      logic       ok;
      logic [2:0] n_in;
      logic [2:0] n_out;
   } ratio_t;

   function automatic ratio_t ratio_decode(input logic [2:0] code);
      ratio_t r;
      r = '0;
      unique case (code)
         3'd0: r = '{ok: 1'b1, n_in: 3'd1, n_out: 3'd1};
         3'd1: r = '{ok: 1'b1, n_in: 3'd2, n_out: 3'd1};
         3'd2: r = '{ok: 1'b1, n_in: 3'd1, n_out: 3'd2};
         3'd3: r = '{ok: 1'b1, n_in: 3'd5, n_out: 3'd2};
         3'd4: r = '{ok: 1'b1, n_in: 3'd2, n_out: 3'd5};
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ftd_period_reg.sv
module ftd_period_reg #(
   parameter int               PER_W   = 32,
   parameter int               BYTE_W  = 8,
   parameter logic [PER_W-1:0] PER_RST = '0,
   localparam int              NBYTES  = PER_W / BYTE_W,
   localparam int              AW      = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [BYTE_W-1:0] cfg_wdata,
   input  logic              upd,
   output logic [PER_W-1:0]  period_active
);

   initial begin
      assert (PER_W % BYTE_W == 0) else $error("period width must be whole bytes");
      assert (NBYTES >= 1) else $error("period needs at least one byte");
   end

   logic [BYTE_W-1:0] shadow_b [NBYTES];
   logic [PER_W-1:0]  shadow_flat;
   logic              upd_q;
   logic              upd_rise;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shadow_b[b] <= PER_RST[b*BYTE_W +: BYTE_W];
         else if (cfg_we && (cfg_addr == AW'(b)))
            shadow_b[b] <= cfg_wdata;
      end
      assign shadow_flat[b*BYTE_W +: BYTE_W] = shadow_b[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_q <= 1'b0;
      else        upd_q <= upd;
   end

   assign upd_rise = upd & ~upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        period_active <= PER_RST;
      else if (upd_rise) period_active <= shadow_flat;
   end

   // R2: no edge, no change
   p_period_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd && !upd_q) |=> $stable(period_active));

   // R1: edge copies the shadow seen at that edge
   p_period_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !upd_q) |=> (period_active == $past(shadow_flat)));

endmodule

// File: rtl/ftd_win_meas.sv
module ftd_win_meas #(
   parameter int CNT_W = 32,
   parameter int FRM_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             vs,
   input  logic [FRM_W-1:0] frames,
   input  logic [CNT_W-1:0] ts,
   output logic             bnd,
   output logic             has_len_nx,
   output logic [CNT_W-1:0] ts_nx,
   output logic [CNT_W-1:0] len_nx
);

   initial begin
      assert (CNT_W >= 8) else $error("window counter too narrow");
      assert (FRM_W >= 1) else $error("frame counter needs a bit");
   end

   logic             vs_q;
   logic             vs_edge;
   logic [FRM_W-1:0] frm_cnt;
   logic             frm_last;
   logic             has_bnd;
   logic             has_len;
   logic [CNT_W-1:0] last_ts;
   logic [CNT_W-1:0] last_len;

   assign vs_edge  = vs & ~vs_q;
   assign frm_last = (frm_cnt == frames - FRM_W'(1));
   assign bnd      = vs_edge && (frm_cnt == '0) && !clr;

   always_comb begin
      has_len_nx = has_len;
      ts_nx      = last_ts;
      len_nx     = last_len;
      if (bnd) begin
         ts_nx = ts;
         if (has_bnd) begin
            has_len_nx = 1'b1;
            len_nx     = ts - last_ts;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vs_q <= 1'b0;
      else        vs_q <= vs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_cnt  <= '0;
         has_bnd  <= 1'b0;
         has_len  <= 1'b0;
         last_ts  <= '0;
         last_len <= '0;
      end else if (clr) begin
         frm_cnt  <= '0;
         has_bnd  <= 1'b0;
         has_len  <= 1'b0;
         last_ts  <= '0;
         last_len <= '0;
      end else begin
         if (vs_edge) frm_cnt <= frm_last ? '0 : frm_cnt + FRM_W'(1);
         if (bnd)     has_bnd <= 1'b1;
         has_len  <= has_len_nx;
         last_ts  <= ts_nx;
         last_len <= len_nx;
      end
   end

   // R6: frame count stays inside the window
   p_frm_range_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (frames != '0) |-> (frm_cnt < frames));

   // R6: a length needs two boundaries
   p_len_after_bnd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      has_len |-> has_bnd);

endmodule

// File: rtl/ftd_err_calc.sv
module ftd_err_calc #(
   parameter int CNT_W   = 32,
   parameter int ERR_W   = 24,
   parameter bit ERR_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             err_mode,
   input  logic             in_bnd,
   input  logic             in_has_len,
   input  logic [CNT_W-1:0] in_ts,
   input  logic [CNT_W-1:0] in_len,
   input  logic             out_bnd,
   input  logic             out_has_len,
   input  logic [CNT_W-1:0] out_ts,
   input  logic [CNT_W-1:0] out_len,
   output logic [ERR_W-1:0] err_word,
   output logic             err_valid
);

   initial begin
      assert (ERR_W <= CNT_W) else $error("error word wider than counters");
      assert (ERR_W >= 2) else $error("error word too narrow");
   end

   logic                    fire;
   logic signed [CNT_W-1:0] freq_raw;
   logic signed [CNT_W-1:0] back;
   logic signed [CNT_W-1:0] fwd;
   logic signed [CNT_W-1:0] phase_raw;
   logic signed [CNT_W-1:0] sel_raw;
   logic [ERR_W-1:0]        clip;
   logic [CNT_W-1:0]        ph_mag;

   assign fire     = in_bnd & in_has_len & out_has_len & !clr;
   assign freq_raw = $signed(out_len - in_len);
   assign back     = out_bnd ? '0 : $signed(out_ts - in_ts);
   assign fwd      = back + $signed(out_len);

   always_comb begin
      if (-back <= fwd) phase_raw = back;
      else              phase_raw = fwd;
   end

   assign sel_raw = err_mode ? freq_raw : phase_raw;
   assign ph_mag  = (phase_raw < 0) ? $unsigned(-phase_raw) : $unsigned(phase_raw);

   if (ERR_SAT) begin : g_sat
      localparam logic signed [CNT_W-1:0] HI =
         {{(CNT_W-ERR_W+1){1'b0}}, {(ERR_W-1){1'b1}}};
      localparam logic signed [CNT_W-1:0] LO = ~HI;
      always_comb begin
         if (sel_raw > HI)      clip = HI[ERR_W-1:0];
         else if (sel_raw < LO) clip = LO[ERR_W-1:0];
         else                   clip = sel_raw[ERR_W-1:0];
      end
   end else begin : g_wrap
      assign clip = sel_raw[ERR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_word  <= '0;
         err_valid <= 1'b0;
      end else if (clr) begin
         err_word  <= '0;
         err_valid <= 1'b0;
      end else begin
         err_valid <= fire;
         if (fire) err_word <= clip;
      end
   end

   // R8: chosen phase lies within half an output window
   p_phase_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !err_mode) |-> ({1'b0, ph_mag, 1'b0} <= {2'b00, out_len}));

   // R9: a result needs both windows measured
   p_valid_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_bnd || !out_has_len) |=> !err_valid);

endmodule

// File: rtl/frame_track_errdet.sv
module frame_track_errdet #(
   parameter int               CNT_W   = 32,
   parameter int               ERR_W   = 24,
   parameter int               PER_W   = 32,
   parameter int               BYTE_W  = 8,
   parameter bit               ERR_SAT = 1'b1,
   parameter logic [PER_W-1:0] PER_RST = '0,
   localparam int              NBYTES  = PER_W / BYTE_W,
   localparam int              ADDR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vs_in,
   input  logic              vs_out,
   input  logic [2:0]        ratio_sel,
   input  logic              err_mode,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [BYTE_W-1:0] cfg_wdata,
   input  logic              period_upd,
   output logic [PER_W-1:0]  period_active,
   output logic [ERR_W-1:0]  err_word,
   output logic              err_valid
);
   import ftd_pkg::*;

   localparam int FRM_W = 3;

   ratio_t           dec;
   logic [2:0]       ratio_q;
   logic             mode_q;
   logic             mode_chg;
   logic             clr;
   logic [CNT_W-1:0] ts;

   logic             in_bnd,  out_bnd;
   logic             in_hl,   out_hl;
   logic [CNT_W-1:0] in_ts,   out_ts;
   logic [CNT_W-1:0] in_len,  out_len;

   assign dec      = ratio_decode(ratio_sel);
   assign mode_chg = (ratio_sel != ratio_q) || (err_mode != mode_q);
   assign clr      = mode_chg || !dec.ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= '0;
         mode_q  <= 1'b0;
      end else begin
         ratio_q <= ratio_sel;
         mode_q  <= err_mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ts <= '0;
      else if (clr) ts <= '0;
      else          ts <= ts + CNT_W'(1);
   end

   ftd_period_reg #(.PER_W(PER_W), .BYTE_W(BYTE_W), .PER_RST(PER_RST)) u_per (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_addr      (cfg_addr),
      .cfg_wdata     (cfg_wdata),
      .upd           (period_upd),
      .period_active (period_active)
   );

   ftd_win_meas #(.CNT_W(CNT_W), .FRM_W(FRM_W)) u_win_in (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .vs         (vs_in),
      .frames     (dec.n_in),
      .ts         (ts),
      .bnd        (in_bnd),
      .has_len_nx (in_hl),
      .ts_nx      (in_ts),
      .len_nx     (in_len)
   );

   ftd_win_meas #(.CNT_W(CNT_W), .FRM_W(FRM_W)) u_win_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .vs         (vs_out),
      .frames     (dec.n_out),
      .ts         (ts),
      .bnd        (out_bnd),
      .has_len_nx (out_hl),
      .ts_nx      (out_ts),
      .len_nx     (out_len)
   );

   ftd_err_calc #(.CNT_W(CNT_W), .ERR_W(ERR_W), .ERR_SAT(ERR_SAT)) u_calc (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .err_mode    (err_mode),
      .in_bnd      (in_bnd),
      .in_has_len  (in_hl),
      .in_ts       (in_ts),
      .in_len      (in_len),
      .out_bnd     (out_bnd),
      .out_has_len (out_hl),
      .out_ts      (out_ts),
      .out_len     (out_len),
      .err_word    (err_word),
      .err_valid   (err_valid)
   );

   // R10: a mode change clears the result on the next cycle
   p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> (err_word == '0) && !err_valid);

   // R5: unsupported ratio codes stay silent
   p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_sel > 3'd4) |=> !err_valid && (err_word == '0));

endmodule

// File: tb/tb_frame_track_errdet.sv
module tb_frame_track_errdet;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        vs_in, vs_out;
   logic [2:0]  ratio_sel;
   logic        err_mode;
   logic        cfg_we;
   logic [1:0]  cfg_addr;
   logic [7:0]  cfg_wdata;
   logic        period_upd;
   logic [31:0] period_active;
   logic [23:0] err_word;
   logic        err_valid;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   frame_track_errdet dut (
      .clk(clk), .rst_n(rst_n), .vs_in(vs_in), .vs_out(vs_out),
      .ratio_sel(ratio_sel), .err_mode(err_mode), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .period_upd(period_upd),
      .period_active(period_active), .err_word(err_word), .err_valid(err_valid)
   );

   // {ratio, mode, in period, out period, out offset, expected error}
   localparam logic [79:0] VEC [12] = '{
      {4'd0, 4'd1, 16'd100, 16'd103, 16'd1,  24'd3},
      {4'd0, 4'd1, 16'd100, 16'd97,  16'd1,  24'hFFFFFD},
      {4'd0, 4'd0, 16'd100, 16'd100, 16'd30, 24'd30},
      {4'd0, 4'd0, 16'd100, 16'd100, 16'd80, 24'hFFFFEC},
      {4'd1, 4'd1, 16'd50,  16'd104, 16'd1,  24'd4},
      {4'd2, 4'd1, 16'd100, 16'd52,  16'd1,  24'd4},
      {4'd3, 4'd1, 16'd40,  16'd101, 16'd1,  24'd2},
      {4'd4, 4'd1, 16'd100, 16'd41,  16'd1,  24'd5},
      {4'd3, 4'd0, 16'd40,  16'd100, 16'd10, 24'hFFFFE2},
      {4'd4, 4'd0, 16'd100, 16'd40,  16'd5,  24'hFFFFA1},
      {4'd1, 4'd0, 16'd50,  16'd100, 16'd60, 24'd10},
      {4'd2, 4'd0, 16'd100, 16'd50,  16'd20, 24'd20}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic [2:0] r, input logic s);
      @(negedge clk);
      vs_in = 1'b0; vs_out = 1'b0;
      ratio_sel = 3'd7;
      @(negedge clk);
      @(negedge clk);
      ratio_sel = r;
      err_mode  = s;
      @(negedge clk);
   endtask

   task automatic run_pulses(input int pin, input int pout, input int off, input int cycles,
                             output logic [23:0] last, output int nval, output int maxrun);
      int run;
      run = 0; nval = 0; maxrun = 0; last = '0;
      for (int t = 1; t <= cycles; t++) begin
         @(negedge clk);
         if (err_valid) begin
            last = err_word; nval++; run++;
            if (run > maxrun) maxrun = run;
         end else run = 0;
         vs_in  = ((t % pin) == 0);
         vs_out = (t >= off) && (((t - off) % pout) == 0);
      end
      @(negedge clk);
      if (err_valid) begin last = err_word; nval++; end
      vs_in = 1'b0; vs_out = 1'b0;
   endtask

   task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      logic [23:0] last;
      int          nval, maxrun;
      rst_n = 1'b0; vs_in = 1'b0; vs_out = 1'b0; ratio_sel = 3'd0; err_mode = 1'b0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; period_upd = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 err_word", 32'(err_word), 0);
      chk("R11 err_valid", 32'(err_valid), 0);
      chk("R11 period", period_active, 0);
      rst_n = 1'b1;

      // period register
      wr_byte(2'd0, 8'h78); wr_byte(2'd1, 8'h56);
      wr_byte(2'd2, 8'h34); wr_byte(2'd3, 8'h12);
      @(negedge clk);
      chk("R2 writes alone keep period", period_active, 0);
      period_upd = 1'b1;
      @(negedge clk);
      chk("R1 rising strobe loads", period_active, 32'h12345678);
      wr_byte(2'd0, 8'hAA);
      repeat (2) @(negedge clk);
      chk("R2 steady high keeps period", period_active, 32'h12345678);
      period_upd = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 falling strobe keeps period", period_active, 32'h12345678);
      period_upd = 1'b1;
      @(negedge clk);
      chk("R1 second rising strobe loads", period_active, 32'h123456AA);
      period_upd = 1'b0;

      // vector table across ratios and modes
      for (int i = 0; i < 12; i++) begin
         set_mode(VEC[i][78:76], VEC[i][72]);
         run_pulses(int'(VEC[i][71:56]), int'(VEC[i][55:40]), int'(VEC[i][39:24]),
                    1000, last, nval, maxrun);
         chk($sformatf("R6 R4 vec%0d results seen", i), 32'(nval != 0), 1);
         chk($sformatf("R3 R7 R8 vec%0d error", i), 32'(last), 32'(VEC[i][23:0]));
         chk($sformatf("R9 vec%0d single-cycle valid", i), 32'(maxrun), 1);
      end

      // unsupported ratio code
      set_mode(3'd5, 1'b1);
      run_pulses(100, 103, 1, 600, last, nval, maxrun);
      chk("R5 no valid on bad code", 32'(nval), 0);
      chk("R5 error held zero", 32'(err_word), 0);

      // mode change mid-run
      set_mode(3'd0, 1'b1);
      run_pulses(100, 103, 1, 350, last, nval, maxrun);
      chk("R7 before change", 32'(err_word), 3);
      err_mode = 1'b0;
      @(negedge clk);
      chk("R10 error cleared", 32'(err_word), 0);
      chk("R10 valid low", 32'(err_valid), 0);
      run_pulses(100, 100, 30, 150, last, nval, maxrun);
      chk("R10 no result before re-measure", 32'(nval), 0);

      finish_run();
   end

endmodule